// File: doc/BRIEF.md
# SPI Master Frame Clock and Delay Sequencer

This block times one SPI master frame from start to finish. A single start pulse opens the chip-select window. The block then waits a programmable setup delay and toggles the serial clock for the programmed number of bits. After the last clock edge it waits a programmable hold delay, closes the window, and waits out a programmable idle gap before it accepts another frame. Shifting, sampling, FIFOs and chip-select routing sit outside. They use this block's one-cycle edge strobes and phase-done pulses.

Each interval is the product of two small lookup tables. The baud period uses a prescaler table and a scaler table, and a double-rate bit halves the result. Each of the three framing delays uses its own prescaler field and scaler field. Two timing-attribute words are presented at the ports, and a select input picks one of them for each frame. The chosen word is captured when the frame is accepted and stays fixed until the frame ends.

Top module: `spi_frame_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sck`, `cs_window`, `busy` and all five strobe and pulse outputs are 0.
- R2: An attribute word is 31 bits:
  - [30:27] frame size F, giving F+1 bits per frame
  - [26] clock idle level CPOL
  - [25] phase CPHA
  - [24] double-rate bit
  - [23:22] baud prescaler index, table {2,3,5,7}
  - [21:18] baud scaler index, table {2,4,6} for indices 0 to 2 and 2^i for i of 3 and above
  - [17:16]/[15:12] setup-delay prescaler and scaler indices
  - [11:10]/[9:6] hold-delay prescaler and scaler indices
  - [5:4]/[3:0] gap prescaler and scaler indices
- R3: The baud period is P = prescaler × scaler module cycles, halved when the double-rate bit is 1. After a leading (even-numbered) edge the next edge comes P/2 (rounded down) cycles later. After a trailing edge it comes P − P/2 cycles later.
- R4: Each framing delay lasts D = {1,3,5,7}[prescaler index] × 2^(scaler index+1) module cycles. With both indices at 0 this gives 2 cycles.
- R5: A start seen while idle raises `cs_window` and `busy` in the next cycle. The first clock edge, together with `lead_done`, appears D_setup cycles after `cs_window` rises.
- R6: D_hold cycles after the last clock edge, `cs_window` falls and `trail_done` pulses. D_gap cycles after that, `gap_done` pulses and `busy` falls.
- R7: A frame has 2×(F+1) clock edges. `sck` takes the CPOL level when the frame is accepted, returns to it after the last edge, and does not change while idle.
- R8: With CPHA = 0, `sample_stb` marks every even edge and `shift_stb` every odd edge except the last. With CPHA = 1, `shift_stb` marks even edges and `sample_stb` odd edges. The two never pulse together.
- R9: `set_sel` = 0 picks `attr_a` and 1 picks `attr_b`, sampled in the cycle the start is accepted.
- R10: Attribute and select changes made after acceptance have no effect on the running frame.
- R11: A start while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame request, accepted only when idle |
| set_sel | input | 1 | Chooses the attribute word for the frame |
| attr_a | input | 31 | Timing attribute word 0 |
| attr_b | input | 31 | Timing attribute word 1 |
| sck | output | 1 | Serial clock |
| cs_window | output | 1 | High from acceptance until the hold delay ends |
| busy | output | 1 | High from acceptance until the gap ends |
| shift_stb | output | 1 | One-cycle pulse with a driving edge |
| sample_stb | output | 1 | One-cycle pulse with a sampling edge |
| lead_done | output | 1 | Setup delay finished, first edge now |
| trail_done | output | 1 | Hold delay finished, window closing |
| gap_done | output | 1 | Idle gap finished, block free |

## Verification
Every result has a fixed due cycle, counted from the clock edge that accepts the start:
- the window opens 1 cycle after that edge;
- the first edge is due D_setup + 1 cycles after it;
- each later edge follows after the P/2 or P − P/2 spacing;
- the window closes D_hold cycles after the last edge;
- the block frees D_gap cycles later.

For each frame, a driver works these cycle offsets out from the chosen attribute word and queues one expected output vector for every cycle in which a strobe pulses or `sck` or `cs_window` changes. A monitor samples at the falling clock edge, counts cycles from the accepting edge, and demands that every activity cycle match the head of the queue in both cycle number and value. Any extra, missing or shifted edge is therefore reported, and so is any effect of a restart or an attribute change made during a frame.

// File: rtl/spi_tim_pkg.sv
`timescale 1ns/1ps
package spi_tim_pkg;

    localparam int ATTR_W = 31;
    localparam int FSZ_W  = 4;
    localparam int CNT_W  = 20;          // holds 7 * 2^16, the longest delay
    localparam int EDGE_W = FSZ_W + 2;   // holds 2 * 2^FSZ_W edges

    typedef struct packed {
        logic [FSZ_W-1:0] fsize;
        logic             cpol;
        logic             cpha;
        logic             dbl;
        logic [1:0]       bpre;
        logic [3:0]       bscl;
        logic [1:0]       lpre;
        logic [3:0]       lscl;
        logic [1:0]       tpre;
        logic [3:0]       tscl;
        logic [1:0]       gpre;
        logic [3:0]       gscl;
    } attr_t;

    localparam attr_t ATTR_RST = '{fsize: 4'd15, default: '0};

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_CLK,
        PH_TRAIL,
        PH_GAP
    } phase_e;

    function automatic logic [CNT_W-1:0] baud_period(input logic [1:0] pre,
                                                     input logic [3:0] scl,
                                                     input logic       dbl);
        logic [2:0]       pv;
        logic [CNT_W-1:0] sv;
        logic [CNT_W-1:0] prod;
        case (pre)
            2'd0:    pv = 3'd2;
            2'd1:    pv = 3'd3;
            2'd2:    pv = 3'd5;
            default: pv = 3'd7;
        endcase
        if (scl < 4'd3) sv = (CNT_W'(scl) << 1) + CNT_W'(2);
        else            sv = CNT_W'(1) << scl;
        prod = sv * CNT_W'(pv);
        return dbl ? (prod >> 1) : prod;
    endfunction

    function automatic logic [CNT_W-1:0] delay_len(input logic [1:0] pre,
                                                   input logic [3:0] scl);
        logic [CNT_W-1:0] sv;
        sv = CNT_W'(2) << scl;
        return sv * CNT_W'({pre, 1'b1});
    endfunction

endpackage

// File: rtl/spi_tim_cnt.sv
`timescale 1ns/1ps
module spi_tim_cnt #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= val - W'(1);
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/spi_tim_attr_sel.sv
`timescale 1ns/1ps
module spi_tim_attr_sel
    import spi_tim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  sel,
    input  attr_t set_a,
    input  attr_t set_b,
    output attr_t act
);
    attr_t held;
    attr_t picked;

    assign picked = sel ? set_b : set_a;

    always_ff @(posedge clk) begin
        if (rst)       held <= ATTR_RST;
        else if (load) held <= picked;
    end

    assign act = load ? picked : held;
endmodule

// File: rtl/spi_tim_seq.sv
`timescale 1ns/1ps
module spi_tim_seq
    import spi_tim_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  attr_t act,
    output logic  load,
    output logic  sck,
    output logic  cs_window,
    output logic  busy,
    output logic  shift_stb,
    output logic  sample_stb,
    output logic  lead_done,
    output logic  trail_done,
    output logic  gap_done
);
    phase_e            st;
    logic [EDGE_W-1:0] ecnt;
    logic [EDGE_W-1:0] nedges;
    logic [CNT_W-1:0]  period, h1, h2;
    logic [CNT_W-1:0]  lead_len, trail_len, gap_len;
    logic              expired, ld, edge_now, last_edge, shift_n, sample_n;
    logic [CNT_W-1:0]  ldval;

    assign period    = baud_period(act.bpre, act.bscl, act.dbl);
    assign h1        = period >> 1;
    assign h2        = period - h1;
    assign lead_len  = delay_len(act.lpre, act.lscl);
    assign trail_len = delay_len(act.tpre, act.tscl);
    assign gap_len   = delay_len(act.gpre, act.gscl);
    assign nedges    = (EDGE_W'(act.fsize) + EDGE_W'(1)) << 1;
    assign last_edge = (ecnt + EDGE_W'(1)) == nedges;

    assign load     = (st == PH_IDLE) && start;
    assign edge_now = expired && ((st == PH_LEAD) || (st == PH_CLK));
    assign shift_n  = edge_now && (act.cpha ? !ecnt[0] : (ecnt[0] && !last_edge));
    assign sample_n = edge_now && (act.cpha ? ecnt[0] : !ecnt[0]);

    always_comb begin
        ld    = 1'b0;
        ldval = '0;
        case (st)
            PH_IDLE:  if (start)   begin ld = 1'b1; ldval = lead_len; end
            PH_LEAD:  if (expired) begin ld = 1'b1; ldval = h1;       end
            PH_CLK:   if (expired) begin
                          ld    = 1'b1;
                          ldval = last_edge ? trail_len : (ecnt[0] ? h2 : h1);
                      end
            PH_TRAIL: if (expired) begin ld = 1'b1; ldval = gap_len;  end
            default:  ;
        endcase
    end

    spi_tim_cnt #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (ld),
        .val     (ldval),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= PH_IDLE;
            ecnt       <= '0;
            sck        <= 1'b0;
            shift_stb  <= 1'b0;
            sample_stb <= 1'b0;
            lead_done  <= 1'b0;
            trail_done <= 1'b0;
            gap_done   <= 1'b0;
        end else begin
            shift_stb  <= shift_n;
            sample_stb <= sample_n;
            lead_done  <= (st == PH_LEAD)  && expired;
            trail_done <= (st == PH_TRAIL) && expired;
            gap_done   <= (st == PH_GAP)   && expired;
            if (edge_now) begin
                sck  <= ~sck;
                ecnt <= ecnt + EDGE_W'(1);
            end
            case (st)
                PH_IDLE: if (start) begin
                    st   <= PH_LEAD;
                    ecnt <= '0;
                    sck  <= act.cpol;
                end
                PH_LEAD:  if (expired) st <= PH_CLK;
                PH_CLK:   if (expired && last_edge) st <= PH_TRAIL;
                PH_TRAIL: if (expired) st <= PH_GAP;
                PH_GAP:   if (expired) st <= PH_IDLE;
                default:  st <= PH_IDLE;
            endcase
        end
    end

    assign cs_window = (st == PH_LEAD) || (st == PH_CLK) || (st == PH_TRAIL);
    assign busy      = (st != PH_IDLE);
endmodule

// File: rtl/spi_frame_timer.sv
`timescale 1ns/1ps
module spi_frame_timer
    import spi_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              set_sel,
    input  logic [ATTR_W-1:0] attr_a,
    input  logic [ATTR_W-1:0] attr_b,
    output logic              sck,
    output logic              cs_window,
    output logic              busy,
    output logic              shift_stb,
    output logic              sample_stb,
    output logic              lead_done,
    output logic              trail_done,
    output logic              gap_done
);
    attr_t act;
    logic  load;

    spi_tim_attr_sel u_sel (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .sel   (set_sel),
        .set_a (attr_t'(attr_a)),
        .set_b (attr_t'(attr_b)),
        .act   (act)
    );

    spi_tim_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .act        (act),
        .load       (load),
        .sck        (sck),
        .cs_window  (cs_window),
        .busy       (busy),
        .shift_stb  (shift_stb),
        .sample_stb (sample_stb),
        .lead_done  (lead_done),
        .trail_done (trail_done),
        .gap_done   (gap_done)
    );
endmodule

// File: rtl/spi_frame_timer_chk.sv
`timescale 1ns/1ps
module spi_frame_timer_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic sck,
    input logic cs_window,
    input logic busy,
    input logic shift_stb,
    input logic sample_stb,
    input logic lead_done,
    input logic trail_done,
    input logic gap_done
);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(shift_stb && sample_stb));

    // R5
    strobe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_stb || sample_stb || lead_done) |-> cs_window);

    // R5
    accept_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (cs_window && busy));

    // R6
    trail_closes_chk: assert property (@(posedge clk) disable iff (rst)
        trail_done |-> (!cs_window && $past(cs_window)));

    // R6
    gap_frees_chk: assert property (@(posedge clk) disable iff (rst)
        gap_done |-> (!busy && $past(busy)));

    // R7
    idle_sck_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> $stable(sck));

    // R6
    done_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lead_done, trail_done, gap_done}));
endmodule

bind spi_frame_timer spi_frame_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sck        (sck),
    .cs_window  (cs_window),
    .busy       (busy),
    .shift_stb  (shift_stb),
    .sample_stb (sample_stb),
    .lead_done  (lead_done),
    .trail_done (trail_done),
    .gap_done   (gap_done)
);

// File: tb/sim_spi_frame_timer.sv
`timescale 1ns/1ps
module sim_spi_frame_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        set_sel = 1'b0;
    logic [30:0] attr_a = '0;
    logic [30:0] attr_b = '0;
    logic        sck, cs_window, busy, shift_stb, sample_stb;
    logic        lead_done, trail_done, gap_done;

    always #2.5 clk = ~clk;

    spi_frame_timer u0 (
        .clk(clk), .rst(rst), .start(start), .set_sel(set_sel),
        .attr_a(attr_a), .attr_b(attr_b), .sck(sck), .cs_window(cs_window),
        .busy(busy), .shift_stb(shift_stb), .sample_stb(sample_stb),
        .lead_done(lead_done), .trail_done(trail_done), .gap_done(gap_done)
    );

    typedef struct {
        int         cyc;
        logic [6:0] m;    // {cs, sck, shift, sample, lead, trail, gap}
    } ev_t;

    ev_t   exq[$];
    int    gcyc = 0;
    int    base = 0;
    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;
    string cur_tag = "R1";
    logic  psck = 1'b0;
    logic  pcs = 1'b0;

    function automatic logic [30:0] mk(input int fs, input int cpol, input int cpha,
                                       input int dbl, input int bp, input int bs,
                                       input int lp, input int ls, input int tp,
                                       input int ts, input int gp, input int gs);
        return {4'(fs), 1'(cpol), 1'(cpha), 1'(dbl), 2'(bp), 4'(bs),
                2'(lp), 4'(ls), 2'(tp), 4'(ts), 2'(gp), 4'(gs)};
    endfunction

    function automatic int bpre_v(input int i);
        case (i)
            0: return 2;
            1: return 3;
            2: return 5;
            default: return 7;
        endcase
    endfunction

    function automatic int bscl_v(input int i);
        if (i < 3) return 2 * i + 2;
        return 1 << i;
    endfunction

    function automatic int dly_v(input int p, input int s);
        return (2 * p + 1) * (2 << s);
    endfunction

    task automatic push_ev(input int c, input logic [6:0] m);
        ev_t e;
        e.cyc = c;
        e.m   = m;
        exq.push_back(e);
    endtask

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected vector per activity cycle
    always @(negedge clk) begin
        logic [6:0] cur;
        gcyc++;
        if (!rst) begin
            cur = {cs_window, sck, shift_stb, sample_stb, lead_done, trail_done, gap_done};
            if ((|cur[4:0]) || sck != psck || cs_window != pcs) begin
                if (exq.size() == 0) begin
                    check({cur_tag, " unexpected activity"}, 1'b0, int'(cur), 0);
                end else begin
                    ev_t e;
                    e = exq.pop_front();
                    check({cur_tag, " event cycle"}, (e.cyc + base) == gcyc,
                          gcyc - base, e.cyc);
                    check({cur_tag, " event value"}, e.m == cur, int'(cur), int'(e.m));
                end
            end
        end
        psck = sck;
        pcs  = cs_window;
    end

    task automatic run_frame(input logic [30:0] wa, input logic [30:0] wb,
                             input bit sel, input bit disturb, input string tag);
        logic [30:0] w;
        int n, p, h1, h2, l, t, g, c, total;
        logic cpol, cpha, lvl, sh, sa;
        w = sel ? wb : wa;
        n = int'(w[30:27]) + 1;
        cpol = w[26];
        cpha = w[25];
        p = bpre_v(int'(w[23:22])) * bscl_v(int'(w[21:18]));
        if (w[24]) p = p / 2;
        h1 = p / 2;
        h2 = p - h1;
        l = dly_v(int'(w[17:16]), int'(w[15:12]));
        t = dly_v(int'(w[11:10]), int'(w[9:6]));
        g = dly_v(int'(w[5:4]), int'(w[3:0]));
        // window opens one cycle after acceptance (R5)
        push_ev(1, {1'b1, cpol, 5'b0});
        c = l + 1;
        lvl = cpol;
        for (int e = 0; e < 2 * n; e++) begin
            lvl = ~lvl;
            sh = cpha ? (e % 2 == 0) : ((e % 2 == 1) && (e != 2 * n - 1));
            sa = cpha ? (e % 2 == 1) : (e % 2 == 0);
            push_ev(c, {1'b1, lvl, sh, sa, (e == 0), 2'b00});
            if (e < 2 * n - 1) c += (e % 2 == 0) ? h1 : h2;
        end
        push_ev(c + t, {1'b0, cpol, 3'b000, 1'b1, 1'b0});
        push_ev(c + t + g, {1'b0, cpol, 4'b0000, 1'b1});
        total = c + t + g;

        cur_tag = tag;
        attr_a  = wa;
        attr_b  = wb;
        set_sel = sel;
        @(negedge clk);
        #1;
        base  = gcyc;
        start = 1'b1;
        @(negedge clk);
        #1;
        start = 1'b0;
        if (disturb) begin
            repeat (2) @(negedge clk);
            #1;
            // R10 R11: restart request and attribute changes mid-frame
            start   = 1'b1;
            attr_a  = ~wa;
            attr_b  = ~wb;
            set_sel = ~sel;
            @(negedge clk);
            #1;
            start = 1'b0;
        end
        while (gcyc < base + total + 2) @(negedge clk);
        #1;
        check({tag, " R6 queue drained"}, exq.size() == 0, exq.size(), 0);
        check({tag, " R6 idle after gap"}, !busy && !cs_window, {busy, cs_window}, 0);
        exq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset outputs", {sck, cs_window, busy, shift_stb, sample_stb,
              lead_done, trail_done, gap_done} == 8'h00,
              {sck, cs_window, busy, shift_stb, sample_stb, lead_done, trail_done, gap_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check("R1 after reset", {sck, cs_window, busy} == 3'b000, {sck, cs_window, busy}, 0);

        // R2 R3 R4: minimum delays, 4-bit frame, CPHA 0
        run_frame(mk(3,0,0,0, 0,0, 0,0, 0,0, 0,0),
                  mk(7,1,1,0, 3,2, 1,1, 1,1, 1,1), 1'b0, 1'b0, "R2 R3 R4 R8 base");
        // R9: second word selected, double rate, odd half periods, CPOL 1 CPHA 1
        run_frame(mk(3,0,0,0, 0,0, 0,0, 0,0, 0,0),
                  mk(4,1,1,1, 1,0, 1,0, 0,1, 2,0), 1'b1, 1'b0, "R9 R3 R8 select-b");
        // R10 R11: single-bit frame, long delays, disturbed mid-frame
        run_frame(mk(0,0,0,0, 2,1, 3,2, 0,0, 3,2),
                  mk(2,1,0,0, 0,0, 0,0, 0,0, 0,0), 1'b0, 1'b1, "R10 R11 R4 hold");
        // R7 R8: 16-bit frame, CPHA 1, double rate
        run_frame(mk(15,0,1,1, 0,3, 0,1, 0,0, 0,0),
                  mk(3,0,0,0, 0,0, 0,0, 0,0, 0,0), 1'b0, 1'b0, "R7 R8 sixteen");
        // R7: idle level 1 held after frame, CPHA 0
        run_frame(mk(0,0,0,0, 0,0, 0,0, 0,0, 0,0),
                  mk(7,1,0,0, 0,0, 0,0, 0,0, 0,0), 1'b1, 1'b0, "R7 R5 cpol-high");
        // R7: idle level returns low, next frame from word a
        repeat (20) @(negedge clk);
        run_frame(mk(1,0,1,0, 1,1, 2,0, 1,0, 0,0),
                  mk(7,1,0,0, 0,0, 0,0, 0,0, 0,0), 1'b0, 1'b1, "R7 R10 R11 cpol-low");

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule